// File: doc/BRIEF.md
# Packing DMA Transfer Channel

This block is one DMA channel that moves a programmed number of bytes from a source address to a destination address over a 32-bit system bus. Software loads a source pointer, a destination pointer and a 24-bit byte count through a small register port. It then writes a control word that holds the start bit. The channel asks for the bus with a request/grant pair. It then runs bus cycles until the count reaches zero or the bus reports an error.

Each side has its own operand width of 8, 16 or 32 bits. Narrow source reads are gathered into wider destination writes, and wide reads are split into narrow writes, so memory can be touched in 32-bit words where the two widths allow it. A dual-address unit reads and then writes. In single-address mode one read cycle per unit moves data straight to a device, and an acknowledge output strobes that device. Transfers are paced either by an external request line or by an internal peripheral request. The bus is either held for the whole count (burst) or given back after every unit (cycle steal). An optional auto-align mode splits unaligned leading bytes into smaller cycles.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads zero, `irq`, `bus_req` and `bus_valid` are low. Register offsets are 0 source pointer, 1 destination pointer, 2 byte count (bits 23:0), 3 control/status. Control bits: 0 start (reads 0), 1 source increment, 2 destination increment, 4:3 source size, 6:5 destination size (0 byte, 1 halfword, 2 word), 7 single-address, 8 burst, 9 auto-align, 10 external trigger select, 11 interrupt enable. Status bits: 16 busy, 17 done, 18 error. When the channel is idle, a control write without start stores the configuration and reads back unchanged.
- R2: In dual-address mode the destination receives exactly the count bytes of the source, in order, for every pair of sizes and any byte alignment. Nothing past the last byte is written. On the bus, data is right-justified, and lower addresses sit in lower byte lanes. `bus_size` uses the size encoding of R1. A cycle holds its address and direction until it receives `bus_ack` or `bus_err`.
- R3: Each unit is the larger of the two operand sizes, cut down to the largest power of two not above the remaining count. A unit is read in source-sized cycles and then written in destination-sized cycles. For 8 aligned bytes this gives 8 reads and 2 writes (byte to word), 2 reads and 8 writes (word to byte), or 4 and 4 (halfword to halfword).
- R4: With auto-align set, no bus cycle is misaligned to its own size, and the copy stays correct.
- R5: A pointer with its increment bit set ends at start value plus count. A pointer with its increment bit clear stays at its start value, so every access uses that one address.
- R6: The count falls by the bytes of each destination write, or of each single-address cycle, and never rises while the channel is busy. A completed transfer leaves the count at 0, done 1, busy 0 and error 0.
- R7: In single-address mode each unit is one read cycle at the source pointer with `ext_ack` high. No write cycle is issued. `ext_ack` is high only while a cycle is presented.
- R8: In burst mode `bus_req` rises once per transfer and stays high until completion. `bus_valid` is never high without `bus_req`.
- R9: In cycle-steal mode `bus_req` falls after every unit. The next unit waits for the selected trigger.
- R10: With bit 10 set only `ext_req` starts units and `periph_req` is ignored. With bit 10 clear only `periph_req` starts units.
- R11: `bus_err` on a cycle ends the transfer at once. It sets error, clears busy and done, and leaves the pointers and the count at the failing access.
- R12: While busy, all register writes, including a new start, are ignored.
- R13: A start with a count of zero sets done at once and requests no bus.
- R14: `irq` is high exactly while interrupt enable is set and done or error is set. A new start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| ext_req | input | 1 | External transfer request |
| ext_ack | output | 1 | Device acknowledge strobe |
| periph_req | input | 1 | Internal peripheral request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Bus cycle presented |
| bus_write | output | 1 | Cycle direction, 1 = write |
| bus_addr | output | ADDR_W | Cycle byte address |
| bus_size | output | 2 | Cycle operand size |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Cycle completed |
| bus_err | input | 1 | Cycle failed |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default 32-bit address and 24-bit count, and keeps every transfer inside a 256-byte model memory. This makes it cheap to sweep all nine pairs of source and destination sizes against four starting byte offsets, five lengths of 1 to 8 bytes, and auto-align both on and off. Those lengths cover the count trimming of the last unit and every misaligned lead-in. Cycle counts, request edges, acknowledge strobes and error aborts are checked in shorter directed transfers.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_ARB, S_RD, S_WR, S_SGL
  } dma_state_e;

  // Packed so that bit 0 lands on control register bit 1
  typedef struct packed {
    logic       int_en;
    logic       trig_ext;
    logic       auto_align;
    logic       burst;
    logic       single;
    logic [1:0] dst_sz;
    logic [1:0] src_sz;
    logic       dst_inc;
    logic       src_inc;
  } dma_cfg_t;

  localparam int CFG_W = $bits(dma_cfg_t);

  function automatic logic [2:0] size_bytes(input logic [1:0] enc);
    case (enc)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_enc(input logic [2:0] n);
    case (n)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] byte_mask(input logic [2:0] n);
    case (n)
      3'd1:    return BUS_W'(32'h0000_00FF);
      3'd2:    return BUS_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

endpackage

// File: rtl/dma_unit_calc.sv
module dma_unit_calc
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic [1:0]       src_lo,
  input  logic [1:0]       dst_lo,
  input  logic [CNT_W-1:0] cnt,
  input  logic [1:0]       src_sz,
  input  logic [1:0]       dst_sz,
  input  logic             single,
  input  logic             auto_align,
  output logic [2:0]       blk_n,
  output logic [2:0]       rd_n,
  output logic [2:0]       wr_n
);

  logic [2:0] sb, db, mx, lim, al;
  logic [1:0] lo;

  always_comb begin
    sb = size_bytes(src_sz);
    db = size_bytes(dst_sz);
    mx = single ? sb : ((sb > db) ? sb : db);

    if (cnt >= CNT_W'(4))      lim = 3'd4;
    else if (cnt >= CNT_W'(2)) lim = 3'd2;
    else                       lim = 3'd1;

    lo = single ? src_lo : (src_lo | dst_lo);
    if (!auto_align)  al = 3'd4;
    else if (lo[0])   al = 3'd1;
    else if (lo[1])   al = 3'd2;
    else              al = 3'd4;

    blk_n = mx;
    if (lim < blk_n) blk_n = lim;
    if (al < blk_n)  blk_n = al;

    rd_n = (sb < blk_n) ? sb : blk_n;
    wr_n = (db < blk_n) ? db : blk_n;
  end

endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf
  import dma_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [2:0]       push_n,
  input  logic [BUS_W-1:0] push_data,
  input  logic             pop,
  input  logic [2:0]       pop_n,
  output logic [BUS_W-1:0] out_data
);

  logic [BUS_W-1:0] data_q;
  logic [2:0]       fill_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      data_q <= data_q | ((push_data & byte_mask(push_n)) << {fill_q, 3'b000});
      fill_q <= fill_q + push_n;
    end else if (pop) begin
      data_q <= data_q >> {pop_n, 3'b000};
    end
  end

  assign out_data = data_q;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ext_req,
  output logic              ext_ack,
  input  logic              periph_req,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              irq
);

  dma_state_e        state_q;
  dma_cfg_t          cfg_q;
  logic [ADDR_W-1:0] src_q, dst_q, bus_addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q, err_q;
  logic              bus_req_q, bus_valid_q, bus_write_q, ext_ack_q;
  logic [1:0]        bus_size_q;
  logic [2:0]        rd_n_q, wr_n_q, rd_left_q, wr_left_q;
  logic [31:0]       reg_rdata_q;

  logic [2:0]        c_blk, c_rd, c_wr;
  logic [BUS_W-1:0]  pk_data;
  logic              trig, fault, rd_ok, wr_ok, sg_ok;
  logic [CNT_W-1:0]  cnt_after_wr, cnt_after_sg;
  logic [ADDR_W-1:0] src_next, dst_next;

  dma_unit_calc #(.CNT_W(CNT_W)) u_calc (
    .src_lo     (src_q[1:0]),
    .dst_lo     (dst_q[1:0]),
    .cnt        (cnt_q),
    .src_sz     (cfg_q.src_sz),
    .dst_sz     (cfg_q.dst_sz),
    .single     (cfg_q.single),
    .auto_align (cfg_q.auto_align),
    .blk_n      (c_blk),
    .rd_n       (c_rd),
    .wr_n       (c_wr)
  );

  assign rd_ok = (state_q == S_RD)  && bus_ack && !bus_err;
  assign wr_ok = (state_q == S_WR)  && bus_ack && !bus_err;
  assign sg_ok = (state_q == S_SGL) && bus_ack && !bus_err;

  dma_pack_buf u_pack (
    .clk       (clk),
    .rst       (rst),
    .clr       ((state_q == S_ARB) && bus_gnt),
    .push      (rd_ok),
    .push_n    (rd_n_q),
    .push_data (bus_rdata),
    .pop       (wr_ok),
    .pop_n     (wr_n_q),
    .out_data  (pk_data)
  );

  assign trig  = cfg_q.trig_ext ? ext_req : periph_req;
  assign fault = bus_err && ((state_q == S_RD) || (state_q == S_WR) || (state_q == S_SGL));
  assign src_next     = cfg_q.src_inc ? src_q + ADDR_W'(rd_n_q) : src_q;
  assign dst_next     = cfg_q.dst_inc ? dst_q + ADDR_W'(wr_n_q) : dst_q;
  assign cnt_after_wr = cnt_q - CNT_W'(wr_n_q);
  assign cnt_after_sg = cnt_q - CNT_W'(rd_n_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      cfg_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      cnt_q       <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      bus_req_q   <= 1'b0;
      bus_valid_q <= 1'b0;
      bus_write_q <= 1'b0;
      ext_ack_q   <= 1'b0;
      bus_addr_q  <= '0;
      bus_size_q  <= '0;
      rd_n_q      <= '0;
      wr_n_q      <= '0;
      rd_left_q   <= '0;
      wr_left_q   <= '0;
    end else if (fault) begin
      bus_valid_q <= 1'b0;
      ext_ack_q   <= 1'b0;
      bus_req_q   <= 1'b0;
      busy_q      <= 1'b0;
      err_q       <= 1'b1;
      state_q     <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (reg_wr) begin
            case (reg_addr)
              2'd0: src_q <= reg_wdata[ADDR_W-1:0];
              2'd1: dst_q <= reg_wdata[ADDR_W-1:0];
              2'd2: cnt_q <= reg_wdata[CNT_W-1:0];
              default: begin
                cfg_q <= dma_cfg_t'(reg_wdata[CFG_W:1]);
                if (reg_wdata[0]) begin
                  err_q <= 1'b0;
                  if (cnt_q == '0) begin
                    done_q <= 1'b1;
                  end else begin
                    done_q  <= 1'b0;
                    busy_q  <= 1'b1;
                    state_q <= S_WAIT;
                  end
                end
              end
            endcase
          end
        end
        S_WAIT: begin
          if (trig) begin
            bus_req_q <= 1'b1;
            state_q   <= S_ARB;
          end
        end
        S_ARB: begin
          if (bus_gnt) begin
            rd_n_q      <= c_rd;
            wr_n_q      <= c_wr;
            rd_left_q   <= c_blk;
            wr_left_q   <= c_blk;
            bus_valid_q <= 1'b1;
            bus_write_q <= 1'b0;
            bus_addr_q  <= src_q;
            bus_size_q  <= size_enc(c_rd);
            ext_ack_q   <= cfg_q.single;
            state_q     <= cfg_q.single ? S_SGL : S_RD;
          end
        end
        S_RD: begin
          if (rd_ok) begin
            src_q <= src_next;
            if (rd_left_q == rd_n_q) begin
              bus_addr_q  <= dst_q;
              bus_size_q  <= size_enc(wr_n_q);
              bus_write_q <= 1'b1;
              ext_ack_q   <= 1'b1;
              state_q     <= S_WR;
            end else begin
              rd_left_q  <= rd_left_q - rd_n_q;
              bus_addr_q <= src_next;
            end
          end
        end
        S_WR: begin
          if (wr_ok) begin
            dst_q <= dst_next;
            cnt_q <= cnt_after_wr;
            if (wr_left_q == wr_n_q) begin
              bus_valid_q <= 1'b0;
              ext_ack_q   <= 1'b0;
              if (cnt_after_wr == '0) begin
                bus_req_q <= 1'b0;
                busy_q    <= 1'b0;
                done_q    <= 1'b1;
                state_q   <= S_IDLE;
              end else if (cfg_q.burst) begin
                state_q <= S_ARB;
              end else begin
                bus_req_q <= 1'b0;
                state_q   <= S_WAIT;
              end
            end else begin
              wr_left_q  <= wr_left_q - wr_n_q;
              bus_addr_q <= dst_next;
            end
          end
        end
        S_SGL: begin
          if (sg_ok) begin
            src_q       <= src_next;
            cnt_q       <= cnt_after_sg;
            bus_valid_q <= 1'b0;
            ext_ack_q   <= 1'b0;
            if (cnt_after_sg == '0) begin
              bus_req_q <= 1'b0;
              busy_q    <= 1'b0;
              done_q    <= 1'b1;
              state_q   <= S_IDLE;
            end else if (cfg_q.burst) begin
              state_q <= S_ARB;
            end else begin
              bus_req_q <= 1'b0;
              state_q   <= S_WAIT;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_q <= '0;
    end else begin
      case (reg_addr)
        2'd0:    reg_rdata_q <= 32'(src_q);
        2'd1:    reg_rdata_q <= 32'(dst_q);
        2'd2:    reg_rdata_q <= 32'(cnt_q);
        default: reg_rdata_q <= 32'({err_q, done_q, busy_q, 4'b0000, cfg_q, 1'b0});
      endcase
    end
  end

  assign reg_rdata = reg_rdata_q;
  assign ext_ack   = ext_ack_q;
  assign bus_req   = bus_req_q;
  assign bus_valid = bus_valid_q;
  assign bus_write = bus_write_q;
  assign bus_addr  = bus_addr_q;
  assign bus_size  = bus_size_q;
  assign bus_wdata = pk_data & byte_mask(wr_n_q);
  assign irq       = cfg_q.int_en && (done_q || err_q);

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [1:0]       addr_lo,
  input logic [1:0]       bus_size,
  input logic             bus_ack,
  input logic             bus_err,
  input logic             ext_ack,
  input logic             irq,
  input logic             busy,
  input logic             auto_align,
  input logic [CNT_W-1:0] cnt
);

  // R2
  cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack && !bus_err) |=> (bus_valid && $stable(addr_lo) && $stable(bus_write)));

  // R4
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && auto_align) |->
      ((bus_size == 2'd2) ? (addr_lo == 2'b00) : ((bus_size == 2'd1) ? !addr_lo[0] : 1'b1)));

  // R6
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cnt <= $past(cnt)));

  // R7
  ack_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ext_ack |-> bus_valid);

  // R8
  req_cover_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_req);

  // R11
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_err) |=> (!bus_valid && !busy));

  // R14
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);

endmodule

bind dma_chan dma_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .addr_lo    (bus_addr[1:0]),
  .bus_size   (bus_size),
  .bus_ack    (bus_ack),
  .bus_err    (bus_err),
  .ext_ack    (ext_ack),
  .irq        (irq),
  .busy       (busy_q),
  .auto_align (cfg_q.auto_align),
  .cnt        (cnt_q)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ext_req, ext_ack, periph_req;
  logic        bus_req, bus_gnt, bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        bus_ack, bus_err, irq;

  logic [7:0]  mem [0:255];
  int          n_rd, n_wr, n_ack, n_mis, n_rise;
  logic        prev_req, hold, err_en;
  logic [7:0]  err_addr;
  int          vectors = 0;
  int          miscompares = 0;

  always #10 clk = ~clk;

  dma_chan u_dma_chan (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
    .ext_ack(ext_ack), .periph_req(periph_req), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq)
  );

  // Bus responder and grant model
  initial begin : responder
    logic [7:0]  a;
    int          nb;
    logic [31:0] rd;
    bus_gnt = 0; bus_ack = 0; bus_err = 0; bus_rdata = 0; prev_req = 0;
    forever begin
      @(negedge clk);
      if (bus_req && !prev_req) n_rise++;
      prev_req = bus_req;
      bus_gnt  = bus_req && !hold;
      if (bus_ack || bus_err) begin
        bus_ack = 0;
        bus_err = 0;
      end else if (bus_valid) begin
        a  = bus_addr[7:0];
        nb = (bus_size == 2'd0) ? 1 : (bus_size == 2'd1) ? 2 : 4;
        if (err_en && a == err_addr) begin
          bus_err = 1;
        end else begin
          if (bus_write) begin
            for (int k = 0; k < nb; k++) mem[8'(a + k)] = bus_wdata[8*k +: 8];
            n_wr++;
          end else begin
            rd = 0;
            for (int k = 0; k < nb; k++) rd[8*k +: 8] = mem[8'(a + k)];
            bus_rdata = rd;
            n_rd++;
          end
          if (ext_ack) n_ack++;
          if ((nb == 4 && a[1:0] != 2'b00) || (nb == 2 && a[0])) n_mis++;
          bus_ack = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit idle = 0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      reg_read(2'd3, v);
      if (!v[16]) idle = 1;
    end
    chk({tag, " completes"}, 32'(idle), 32'd1);
  endtask

  function automatic logic [10:0] mk(input bit si, input bit di, input logic [1:0] ss,
                                     input logic [1:0] ds, input bit sg, input bit bu,
                                     input bit aa, input bit ex, input bit ie);
    return {ie, ex, aa, bu, sg, ds, ss, di, si};
  endfunction

  task automatic run(input logic [7:0] s, input logic [7:0] d, input int n, input logic [10:0] cfg);
    n_rd = 0; n_wr = 0; n_ack = 0; n_mis = 0; n_rise = 0;
    reg_write(2'd0, 32'(s));
    reg_write(2'd1, 32'(d));
    reg_write(2'd2, 32'(n));
    reg_write(2'd3, {20'd0, cfg, 1'b1});
  endtask

  function automatic int copy_bad(input logic [7:0] s, input logic [7:0] d, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[8'(d + i)] !== mem[8'(s + i)]) bad++;
    if (mem[8'(d + n)] !== 8'h00) bad++;
    return bad;
  endfunction

  task automatic prep(input logic [7:0] s, input logic [7:0] d, input int seed);
    for (int i = 0; i < 16; i++) mem[8'(s + i)] = 8'((i * 37 + seed) | 1);
    for (int i = 0; i < 16; i++) mem[8'(d + i)] = 8'h00;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    logic [7:0]  s, d;
    int          n;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    ext_req = 0; periph_req = 1; hold = 0; err_en = 0; err_addr = 0;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 bus_valid", 32'(bus_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    for (int r = 0; r < 4; r++) begin
      reg_read(2'(r), v);
      chk("R1 reset readback", v, 0);
    end
    reg_write(2'd3, {20'd0, mk(1, 0, 2'd2, 2'd1, 1, 0, 1, 0, 1), 1'b0});
    reg_read(2'd3, v);
    chk("R1 config readback", v, {20'd0, mk(1, 0, 2'd2, 2'd1, 1, 0, 1, 0, 1), 1'b0});

    // R2 R4 R5 R6 sweep
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int aa = 0; aa < 2; aa++)
          for (int off = 0; off < 4; off++)
            for (int ci = 0; ci < 5; ci++) begin
              n = (ci == 0) ? 1 : (ci == 1) ? 3 : (ci == 2) ? 4 : (ci == 3) ? 7 : 8;
              s = 8'h10 + 8'(off);
              d = 8'h80 + 8'((off + 1) % 4);
              prep(s, d, ss * 11 + ds * 5 + off + ci);
              run(s, d, n, mk(1, 1, 2'(ss), 2'(ds), 0, 1, aa[0], 0, 0));
              wait_idle("R2");
              chk("R2 copy mismatches", 32'(copy_bad(s, d, n)), 0);
              if (aa == 1) chk("R4 misaligned cycles", 32'(n_mis), 0);
              reg_read(2'd0, v); chk("R5 src end", v, 32'(s) + 32'(n));
              reg_read(2'd1, v); chk("R5 dst end", v, 32'(d) + 32'(n));
              reg_read(2'd2, v); chk("R6 count zero", v, 0);
              reg_read(2'd3, v); chk("R6 status", 32'(v[18:16]), 32'b010);
            end

    // R3 cycle counts
    prep(8'h20, 8'h90, 3);
    run(8'h20, 8'h90, 8, mk(1, 1, 2'd0, 2'd2, 0, 1, 0, 0, 0)); wait_idle("R3");
    chk("R3 pack reads", 32'(n_rd), 8); chk("R3 pack writes", 32'(n_wr), 2);
    run(8'h20, 8'h90, 8, mk(1, 1, 2'd2, 2'd0, 0, 1, 0, 0, 0)); wait_idle("R3");
    chk("R3 unpack reads", 32'(n_rd), 2); chk("R3 unpack writes", 32'(n_wr), 8);
    run(8'h20, 8'h90, 8, mk(1, 1, 2'd1, 2'd1, 0, 1, 0, 0, 0)); wait_idle("R3");
    chk("R3 half reads", 32'(n_rd), 4); chk("R3 half writes", 32'(n_wr), 4);
    // R8 one request edge in burst
    chk("R8 burst request edges", 32'(n_rise), 1);

    // R5 constant source
    prep(8'h30, 8'hA0, 9);
    run(8'h30, 8'hA0, 4, mk(0, 1, 2'd0, 2'd0, 0, 1, 0, 0, 0)); wait_idle("R5");
    v = 0; for (int i = 0; i < 4; i++) if (mem[8'hA0 + i] !== mem[8'h30]) v++;
    chk("R5 fixed source data", v, 0);
    reg_read(2'd0, v); chk("R5 fixed source pointer", v, 32'h30);
    // R5 constant destination
    prep(8'h30, 8'hA0, 13);
    run(8'h30, 8'hA0, 4, mk(1, 0, 2'd0, 2'd0, 0, 1, 0, 0, 0)); wait_idle("R5");
    chk("R5 fixed dest data", 32'(mem[8'hA0]), 32'(mem[8'h33]));
    reg_read(2'd1, v); chk("R5 fixed dest pointer", v, 32'hA0);

    // R7 single address
    run(8'h40, 8'hB0, 6, mk(1, 1, 2'd1, 2'd0, 1, 1, 0, 0, 0)); wait_idle("R7");
    chk("R7 single reads", 32'(n_rd), 3);
    chk("R7 single writes", 32'(n_wr), 0);
    chk("R7 ack strobes", 32'(n_ack), 3);
    reg_read(2'd0, v); chk("R7 src end", v, 32'h46);
    reg_read(2'd2, v); chk("R7 count zero", v, 0);

    // R9 cycle steal, internal trigger
    prep(8'h20, 8'h90, 21);
    run(8'h20, 8'h90, 8, mk(1, 1, 2'd0, 2'd0, 0, 0, 0, 0, 0)); wait_idle("R9");
    chk("R9 steal request edges", 32'(n_rise), 8);
    chk("R9 steal copy", 32'(copy_bad(8'h20, 8'h90, 8)), 0);

    // R10 external trigger select, R9 one unit per request
    prep(8'h60, 8'hA0, 29);
    run(8'h60, 8'hA0, 4, mk(1, 1, 2'd0, 2'd0, 0, 0, 0, 1, 0));
    repeat (20) @(negedge clk);
    chk("R10 periph ignored edges", 32'(n_rise), 0);
    reg_read(2'd2, v); chk("R10 count untouched", v, 4);
    ext_req = 1;
    wait (n_ack == 1);
    ext_req = 0;
    repeat (20) @(negedge clk);
    reg_read(2'd2, v); chk("R9 one unit per request", v, 3);
    ext_req = 1;
    wait_idle("R10");
    ext_req = 0;
    chk("R10 external copy", 32'(copy_bad(8'h60, 8'hA0, 4)), 0);

    // R11 bus error, R14 irq on error
    prep(8'h50, 8'h90, 33);
    err_en = 1; err_addr = 8'h52;
    run(8'h50, 8'h90, 6, mk(1, 1, 2'd0, 2'd0, 0, 1, 0, 0, 1)); wait_idle("R11");
    err_en = 0;
    reg_read(2'd3, v); chk("R11 status", 32'(v[18:16]), 32'b100);
    reg_read(2'd0, v); chk("R11 src at fault", v, 32'h52);
    reg_read(2'd1, v); chk("R11 dst at fault", v, 32'h92);
    reg_read(2'd2, v); chk("R11 count at fault", v, 4);
    chk("R14 irq on error", 32'(irq), 1);

    // R12 writes ignored while busy, R14 cleared by start
    prep(8'h30, 8'hB0, 41);
    hold = 1;
    run(8'h30, 8'hB0, 4, mk(1, 1, 2'd0, 2'd0, 0, 1, 0, 0, 1));
    repeat (5) @(negedge clk);
    chk("R14 irq cleared on start", 32'(irq), 0);
    reg_write(2'd0, 32'h55);
    reg_write(2'd3, {20'd0, mk(0, 0, 2'd2, 2'd2, 1, 0, 0, 0, 0), 1'b1});
    reg_read(2'd0, v); chk("R12 src write ignored", v, 32'h30);
    reg_read(2'd3, v); chk("R12 config ignored", v[11:0], {mk(1, 1, 2'd0, 2'd0, 0, 1, 0, 0, 1), 1'b0});
    chk("R12 still busy", 32'(v[16]), 1);
    hold = 0;
    wait_idle("R12");
    reg_read(2'd0, v); chk("R12 src end", v, 32'h34);
    chk("R12 copy", 32'(copy_bad(8'h30, 8'hB0, 4)), 0);
    chk("R14 irq on done", 32'(irq), 1);

    // R13 zero count, R14 irq masked
    run(8'h30, 8'hB0, 0, mk(1, 1, 2'd0, 2'd0, 0, 1, 0, 0, 0));
    repeat (4) @(negedge clk);
    reg_read(2'd3, v); chk("R13 zero count status", 32'(v[18:16]), 32'b010);
    chk("R13 no bus request", 32'(n_rise), 0);
    chk("R14 irq masked", 32'(irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule